// File: doc/BRIEF.md
# PMIC Register Command Bridge

This block lets a host processor reach the 16-bit registers of an external power-management device, one transfer at a time, through three memory-mapped registers. Software writes a command word that holds the direction, a 15-bit target register address and, for writes, 16 bits of data. The bridge then presents that command on a parallel request/acknowledge port that feeds a serial link. Software polls a status register until the transfer is finished.

A write command returns the bridge to idle as soon as the far side acknowledges. A read command captures the returned data on the acknowledge and parks the bridge in a valid state. The data stays there until software writes an explicit clear. Software must see the idle code before it issues any new command. A command offered at any other time is dropped.

Top module: `pmic_cmd_bridge`

## Requirements
- R1: After reset the engine state is idle (code 0), the downstream request is low and the registered host read data is zero.
- R2: A host read returns data on the clock edge that samples it. Offset 0xA4 reads {13'b0, state[2:0] in bits 18:16, last captured read data in bits 15:0}. Offsets 0xA0, 0xA8 and every unmapped offset read as zero.
- R3: A host write to offset 0xA0 while idle starts a transfer. From the next cycle dn_req is high, dn_wr equals bit 31 (1 = write, 0 = read), dn_addr equals bits 30:16 and dn_wdata equals bits 15:0. The state code becomes 1 for a write and 2 for a read.
- R4: While dn_req is high and dn_ack is low, dn_req stays high and dn_wr, dn_addr and dn_wdata stay stable.
- R5: A write transfer that sees dn_ack returns to idle (code 0) on the next cycle with dn_req low. It never shows code 6.
- R6: A read transfer that sees dn_ack captures dn_rdata and shows code 6 with that data in bits 15:0 from the next cycle. dn_req is low from then on.
- R7: Code 6 and its data are held until a host write to offset 0xA8 with bit 0 = 1, which returns the state to idle. A write to 0xA8 with bit 0 = 0 has no effect. The data field keeps the captured value after the clear.
- R8: A command write to 0xA0 while the state is not idle is ignored. The pending request fields, the state and the read data do not change.
- R9: dn_ack while no transfer is pending has no effect on the state or the read data.
- R10: A valid-clear write while a transfer is pending has no effect. The request stays up and the busy code is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Host byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data |
| dn_req | output | 1 | Downstream transfer request, held until acknowledged |
| dn_wr | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 15 | Downstream target register address |
| dn_wdata | output | 16 | Downstream write data |
| dn_ack | input | 1 | Downstream completion pulse |
| dn_rdata | input | 16 | Downstream read data, valid with dn_ack |

## Verification
A host read of the status register can land in the same cycle as the downstream acknowledge of a pending read. The bench provokes this by raising dn_ack and a status read on the same falling edge. The read must return the busy code 2 together with the old data field, because the register samples the state before that edge updates it. A second read must then show code 6 with the new data. The bench also places a command write and a valid-clear write into busy cycles to confirm that neither one disturbs the request in flight.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;

    localparam int HOST_W  = 32;
    localparam int REG_W   = 16;
    localparam int TADDR_W = 15;
    localparam int CODE_W  = 3;
    localparam int PAD_W   = HOST_W - CODE_W - REG_W;

    typedef enum logic [CODE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_WR_BUSY = 3'd1,
        ST_RD_BUSY = 3'd2,
        ST_VALID   = 3'd6
    } eng_state_e;

    typedef struct packed {
        eng_state_e         st;
        logic               wr;
        logic [TADDR_W-1:0] taddr;
        logic [REG_W-1:0]   wdata;
        logic [REG_W-1:0]   rdata;
    } eng_regs_t;

endpackage

// File: rtl/pmic_regdec.sv
module pmic_regdec #(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  CMD_OFS  = 8'hA0,
    parameter logic [7:0]  STAT_OFS = 8'hA4,
    parameter logic [7:0]  CLR_OFS  = 8'hA8
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wbit0,
    output logic              cmd_wr,
    output logic              clr_wr,
    output logic              rd_en,
    output logic              rd_stat
);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFS);

    always_comb begin
        cmd_wr  = bus_en && bus_we && (bus_addr == CMD_A);
        clr_wr  = bus_en && bus_we && (bus_addr == CLR_A) && wbit0;
        rd_en   = bus_en && !bus_we;
        rd_stat = bus_addr == STAT_A;
    end
endmodule

// File: rtl/pmic_seq.sv
module pmic_seq
    import pmic_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [HOST_W-1:0]  cmd_word,
    input  logic               clr_wr,
    input  logic               dn_ack,
    input  logic [REG_W-1:0]   dn_rdata,
    output logic               dn_req,
    output logic               dn_wr,
    output logic [TADDR_W-1:0] dn_addr,
    output logic [REG_W-1:0]   dn_wdata,
    output logic [CODE_W-1:0]  state_code,
    output logic [REG_W-1:0]   rd_data
);
    eng_regs_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        unique case (eng_q.st)
            ST_IDLE: if (cmd_wr) begin
                eng_d.wr    = cmd_word[HOST_W-1];
                eng_d.taddr = cmd_word[HOST_W-2 -: TADDR_W];
                eng_d.wdata = cmd_word[REG_W-1:0];
                eng_d.st    = cmd_word[HOST_W-1] ? ST_WR_BUSY : ST_RD_BUSY;
            end
            ST_WR_BUSY: if (dn_ack) eng_d.st = ST_IDLE;
            ST_RD_BUSY: if (dn_ack) begin
                eng_d.rdata = dn_rdata;
                eng_d.st    = ST_VALID;
            end
            ST_VALID: if (clr_wr) eng_d.st = ST_IDLE;
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q.st    <= ST_IDLE;
            eng_q.wr    <= 1'b0;
            eng_q.taddr <= '0;
            eng_q.wdata <= '0;
            eng_q.rdata <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        dn_req     = (eng_q.st == ST_WR_BUSY) || (eng_q.st == ST_RD_BUSY);
        dn_wr      = eng_q.wr;
        dn_addr    = eng_q.taddr;
        dn_wdata   = eng_q.wdata;
        state_code = eng_q.st;
        rd_data    = eng_q.rdata;
    end

    // R4: request and its fields held until acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_wr) && $stable(dn_wdata));
    // R5: write completion goes straight to idle
    p_wr_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_wr && dn_ack |=> state_code == 3'd0 && !dn_req);
    // R6: read completion captures data and shows valid
    p_rd_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_wr && dn_ack |=> state_code == 3'd6 && rd_data == $past(dn_rdata));
    // R7: valid held until a clear
    p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd6 && !clr_wr |=> state_code == 3'd6 && $stable(rd_data));
    // R8: command ignored when not idle
    p_cmd_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd6 && cmd_wr |=> !dn_req);
    // R9: stray acknowledge in idle has no effect
    p_stray_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd0 && !cmd_wr && dn_ack |=> state_code == 3'd0 && $stable(rd_data));
endmodule

// File: rtl/pmic_readback.sv
module pmic_readback
    import pmic_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_stat,
    input  logic [CODE_W-1:0] state_code,
    input  logic [REG_W-1:0]  rd_data,
    output logic [HOST_W-1:0] rdata
);
    logic [HOST_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) rdata_d = rd_stat ? {{PAD_W{1'b0}}, state_code, rd_data} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/pmic_cmd_bridge.sv
module pmic_cmd_bridge
    import pmic_bridge_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] CMD_OFS  = 8'hA0,
    parameter logic [7:0] STAT_OFS = 8'hA4,
    parameter logic [7:0] CLR_OFS  = 8'hA8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               dn_req,
    output logic               dn_wr,
    output logic [14:0]        dn_addr,
    output logic [15:0]        dn_wdata,
    input  logic               dn_ack,
    input  logic [15:0]        dn_rdata
);
    logic              cmd_wr, clr_wr, rd_en, rd_stat;
    logic [CODE_W-1:0] state_code;
    logic [REG_W-1:0]  rd_data;

    pmic_regdec #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .STAT_OFS(STAT_OFS), .CLR_OFS(CLR_OFS)) u_dec (
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .wbit0(bus_wdata[0]),
        .cmd_wr(cmd_wr), .clr_wr(clr_wr), .rd_en(rd_en), .rd_stat(rd_stat)
    );

    pmic_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(bus_wdata), .clr_wr(clr_wr),
        .dn_ack(dn_ack), .dn_rdata(dn_rdata), .dn_req(dn_req), .dn_wr(dn_wr),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .state_code(state_code), .rd_data(rd_data)
    );

    pmic_readback u_rb (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_stat(rd_stat),
        .state_code(state_code), .rd_data(rd_data), .rdata(bus_rdata)
    );

    // R3: accepted command appears on the downstream port
    p_cmd_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'd0 && cmd_wr |=> dn_req && dn_addr == $past(bus_wdata[30:16])
                                          && dn_wr == $past(bus_wdata[31]));
    // R10: clear during a pending transfer keeps the request
    p_clr_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack && clr_wr |=> dn_req);
endmodule

// File: tb/pmic_cmd_bridge_test.sv
`timescale 1ns/1ps
module pmic_cmd_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dn_req, dn_wr;
    logic [14:0] dn_addr;
    logic [15:0] dn_wdata;
    logic        dn_ack = 1'b0;
    logic [15:0] dn_rdata = '0;

    int checks = 0, fails = 0;
    logic [15:0] last_rd = '0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    pmic_cmd_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dn_req(dn_req), .dn_wr(dn_wr),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    // {wr, target address, write data, reply data}
    localparam logic [47:0] VEC [6] = '{
        {1'b1, 15'h0110, 16'h0040, 16'h0000},
        {1'b0, 15'h0110, 16'h0000, 16'h0040},
        {1'b0, 15'h7FFF, 16'h0000, 16'hFFFF},
        {1'b1, 15'h0000, 16'hFFFF, 16'h0000},
        {1'b0, 15'h2A55, 16'h0000, 16'h8001},
        {1'b1, 15'h5AA5, 16'h1234, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic pulse_ack(input logic [15:0] v);
        @(negedge clk);
        dn_ack = 1'b1; dn_rdata = v;
        @(negedge clk);
        dn_ack = 1'b0;
    endtask

    function automatic logic [31:0] stat(input logic [2:0] c, input logic [15:0] d);
        return {13'b0, c, d};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 req", {31'b0, dn_req}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        bus_read(8'hA4, rv); check("R1 status", rv, stat(3'd0, 16'h0));

        // R2: write-only and unmapped offsets read zero
        bus_read(8'h10, rv); check("R2 unmapped", rv, 32'h0);
        bus_read(8'hA0, rv); check("R2 cmd reg", rv, 32'h0);
        bus_read(8'hA8, rv); check("R2 clr reg", rv, 32'h0);

        for (int i = 0; i < 6; i++) begin
            logic        w;
            logic [14:0] ta;
            logic [15:0] wd, ad;
            {w, ta, wd, ad} = VEC[i];
            bus_write(8'hA0, {w, ta, wd});
            check("R3 req", {31'b0, dn_req}, 32'h1);
            check("R3 fields", {dn_wr, dn_addr, dn_wdata}, {w, ta, wd});
            bus_read(8'hA4, rv); check("R3 busy code", rv, stat(w ? 3'd1 : 3'd2, last_rd));
            repeat (2) @(negedge clk);
            check("R4 held", {dn_req, dn_wr, dn_addr, dn_wdata}, {1'b1, w, ta, wd});
            pulse_ack(ad);
            check("R5/R6 req drop", {31'b0, dn_req}, 32'h0);
            if (w) begin
                bus_read(8'hA4, rv); check("R5 idle", rv, stat(3'd0, last_rd));
            end else begin
                last_rd = ad;
                bus_read(8'hA4, rv); check("R6 valid", rv, stat(3'd6, ad));
                bus_write(8'hA8, 32'h1);
                bus_read(8'hA4, rv); check("R7 cleared", rv, stat(3'd0, ad));
            end
        end

        // R8: command while busy ignored
        bus_write(8'hA0, {1'b0, 15'h0123, 16'h0000});
        bus_write(8'hA0, {1'b1, 15'h4444, 16'hBEEF});
        check("R8 busy ignore", {dn_req, dn_wr, dn_addr, dn_wdata}, {1'b1, 1'b0, 15'h0123, 16'h0000});
        // same-cycle: status read with acknowledge (R6)
        @(negedge clk);
        dn_ack = 1'b1; dn_rdata = 16'hC3C3;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 8'hA4;
        @(posedge clk);
        #1 rv = bus_rdata;
        @(negedge clk);
        dn_ack = 1'b0; bus_en = 1'b0;
        check("R6 same-cycle old view", rv, stat(3'd2, last_rd));
        last_rd = 16'hC3C3;
        bus_read(8'hA4, rv); check("R6 after ack", rv, stat(3'd6, 16'hC3C3));
        // R8: command while valid ignored
        bus_write(8'hA0, {1'b1, 15'h0001, 16'h0001});
        check("R8 valid ignore req", {31'b0, dn_req}, 32'h0);
        bus_read(8'hA4, rv); check("R8 valid kept", rv, stat(3'd6, 16'hC3C3));
        // R7: clear with bit0 = 0 ignored
        bus_write(8'hA8, 32'hFFFF_FFFE);
        bus_read(8'hA4, rv); check("R7 bit0 zero", rv, stat(3'd6, 16'hC3C3));
        bus_write(8'hA8, 32'h1);
        bus_read(8'hA4, rv); check("R7 clear", rv, stat(3'd0, 16'hC3C3));

        // R9: stray acknowledge in idle
        pulse_ack(16'hDEAD);
        bus_read(8'hA4, rv); check("R9 stray ack", rv, stat(3'd0, 16'hC3C3));
        check("R9 no req", {31'b0, dn_req}, 32'h0);

        // R10: clear during pending write
        bus_write(8'hA0, {1'b1, 15'h0077, 16'h0011});
        bus_write(8'hA8, 32'h1);
        check("R10 req kept", {31'b0, dn_req}, 32'h1);
        bus_read(8'hA4, rv); check("R10 busy kept", rv, stat(3'd1, 16'hC3C3));
        pulse_ack(16'h0);
        bus_read(8'hA4, rv); check("R10 done", rv, stat(3'd0, 16'hC3C3));

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule